// File: doc/BRIEF.md
# DSP Host-Memory Window Bridge

This bridge lets a 16-bit signal-processing coprocessor reach a region of the host processor's RAM through its I/O ports. The DSP loads an address register on one port and then moves words to or from host RAM through a data port. The host RAM sits behind a simple synchronous word port that completes each access in one cycle. A third DSP port drives the DSP's branch-condition input (BIO) and finishes a handoff that gives the bus back to the host.

The bridge also manages which processor runs. A host control command starts the DSP, raises the DSP interrupt and halts the host. A second command stops the DSP. To hand back, the DSP first writes zero to one of the first two words of the window, which arms an execute flag. It then writes zero to the control port, which releases the host halt.

There is no back-pressure on either side. Each strobe is a single-cycle access that always completes. A port 1 read returns its word with a one-cycle valid pulse on the cycle after the strobe. Only one access is outstanding at a time.

Top module: `dsp_hostwin_bridge`

## Requirements
- R1: After reset, the outputs are as follows:
  - `dsp_halt` is 1, `dsp_int` is 0, `host_halt` is 0 and `dsp_bio` is 0.
  - `dsp_io_rvalid` is 0.
  - The segment code is 0, so a port 1 read returns 0 and raises no `ram_en`.
  - The execute flag is clear.
- R2: A DSP write to port 0 loads two fields. The word offset is data[12:0], which is byte offset data[12:0]<<1. The segment code is data[15:13], which forms byte-address bits 24:22. Host accesses present the word offset on `ram_addr`.
- R3: Only segment code 3 maps to host RAM (byte base 0xC00000). During a port 1 write strobe in that segment, the same cycle drives the following:
  - `ram_en` = 1 and `ram_we` = 1;
  - `ram_addr` = the word offset;
  - `ram_wdata` = the DSP data.
- R4: A port 1 read strobe in segment 3 issues a RAM read in the same cycle. On the next cycle, `dsp_io_rvalid` is 1 and `dsp_io_rdata` holds the stored word. `dsp_io_rdata` is 0 whenever `dsp_io_rvalid` is 0.
- R5: In any segment other than 3:
  - a port 1 write raises no `ram_en` and leaves host RAM unchanged;
  - a port 1 read still pulses `dsp_io_rvalid` on the next cycle, with data 0.
- R6: Every port 1 write clears the execute flag. The same write then sets the flag only if all of the following hold:
  - the segment is 3;
  - the byte offset is below 3 (word offset 0 or 1);
  - the data is 0x0000.
- R7: A DSP port 3 write acts on its data as follows:
  - data bit 15 set makes `dsp_bio` 0 on the next cycle;
  - exactly 0x0000 makes `dsp_bio` 1 and, if the execute flag is set, clears `host_halt` and the flag;
  - any other value changes nothing.
- R8: A host control write with the low byte lane enabled and data 0x00 sets these outputs on the next cycle:
  - `dsp_halt` = 0;
  - `dsp_int` = 1;
  - `host_halt` = 1.

  This command takes precedence over a release in the same cycle.
- R9: A host control write of 0x01 on the low byte lane makes `dsp_int` 0 and `dsp_halt` 1. Any other value, or a write with the low lane disabled, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_io_we | input | 1 | DSP I/O write strobe |
| dsp_io_re | input | 1 | DSP I/O read strobe |
| dsp_io_port | input | 2 | DSP I/O port number (0 address, 1 data, 3 control) |
| dsp_io_wdata | input | 16 | DSP I/O write data |
| dsp_io_rdata | output | 16 | Port 1 read data, valid with dsp_io_rvalid |
| dsp_io_rvalid | output | 1 | Read data valid, one cycle after a port 1 read strobe |
| dsp_bio | output | 1 | BIO condition to the DSP, 1 = asserted |
| dsp_int | output | 1 | Interrupt to the DSP |
| dsp_halt | output | 1 | Holds the DSP halted |
| host_halt | output | 1 | Holds the host processor halted |
| host_ctl_we | input | 1 | Host control register write strobe |
| host_ctl_lo_en | input | 1 | Host low byte lane enable |
| host_ctl_wdata | input | 8 | Host control low byte |
| ram_en | output | 1 | Host RAM access enable |
| ram_we | output | 1 | Host RAM write enable |
| ram_addr | output | 13 | Host RAM word address |
| ram_wdata | output | 16 | Host RAM write data |
| ram_rdata | input | 16 | Host RAM read data, one cycle after a read |

## Verification
The assertions assume the following about the inputs:
- the DSP never raises its read and write strobes together;
- a strobe lasts one cycle;
- host RAM returns read data on the cycle after `ram_en`.

The assertions also take the valid pulse to follow only a port 1 read, and expect no other source to change BIO. The bench drives each strobe for a single cycle between idle cycles, models host RAM as a one-cycle synchronous memory, and never overlaps DSP and host commands. The same-cycle precedence in R8 therefore appears only as a requirement and is never exercised.

// File: rtl/dsp_hw_pkg.sv
package dsp_hw_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_DATA = 2'd1,
    PORT_RSV  = 2'd2,
    PORT_CTRL = 2'd3
  } dsp_port_e;

  localparam logic [7:0] HCMD_RUN_DSP  = 8'h00;
  localparam logic [7:0] HCMD_STOP_DSP = 8'h01;
endpackage

// File: rtl/dsp_win_addr.sv
module dsp_win_addr #(
  parameter int DATA_W      = 16,
  parameter int SEG_W       = 3,
  parameter int HOST_SEG    = 3,
  parameter int ARM_LIMIT_B = 3,
  localparam int OFS_W      = DATA_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  ofs,
  output logic              seg_hit,
  output logic              ofs_low
);
  logic [SEG_W-1:0] seg_q;
  logic [OFS_W:0]   byte_ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs   <= '0;
      seg_q <= '0;
    end else if (ld) begin
      ofs   <= wdata[OFS_W-1:0];
      seg_q <= wdata[DATA_W-1:OFS_W];
    end
  end

  assign byte_ofs = {ofs, 1'b0};
  assign seg_hit  = (seg_q == SEG_W'(HOST_SEG));
  assign ofs_low  = (byte_ofs < (OFS_W+1)'(ARM_LIMIT_B));
endmodule

// File: rtl/dsp_win_access.sv
module dsp_win_access #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              hit,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [OFS_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      rvalid <= rd_req;
      hit_q  <= hit;
    end
  end

  assign ram_en    = (rd_req || wr_req) && hit;
  assign ram_we    = wr_req && hit;
  assign ram_addr  = ofs;
  assign ram_wdata = wdata;
  assign rdata     = (rvalid && hit_q) ? ram_rdata : '0;
endmodule

// File: rtl/dsp_run_ctrl.sv
module dsp_run_ctrl
  import dsp_hw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_arm,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_data,
  input  logic              host_wr,
  input  logic [7:0]        host_data,
  output logic              bio,
  output logic              dsp_int,
  output logic              dsp_halt,
  output logic              host_halt
);
  logic exec_q;
  logic ctrl_zero;
  logic release_host;
  logic cmd_run;
  logic cmd_stop;

  assign ctrl_zero    = ctrl_wr && (ctrl_data == '0);
  assign release_host = ctrl_zero && exec_q;
  assign cmd_run      = host_wr && (host_data == HCMD_RUN_DSP);
  assign cmd_stop     = host_wr && (host_data == HCMD_STOP_DSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q    <= 1'b0;
      bio       <= 1'b0;
      dsp_int   <= 1'b0;
      dsp_halt  <= 1'b1;
      host_halt <= 1'b0;
    end else begin
      if (data_wr)
        exec_q <= data_arm;
      else if (release_host)
        exec_q <= 1'b0;

      if (ctrl_wr && ctrl_data[DATA_W-1])
        bio <= 1'b0;
      else if (ctrl_zero)
        bio <= 1'b1;

      if (cmd_run)
        host_halt <= 1'b1;
      else if (release_host)
        host_halt <= 1'b0;

      if (cmd_run) begin
        dsp_int  <= 1'b1;
        dsp_halt <= 1'b0;
      end else if (cmd_stop) begin
        dsp_int  <= 1'b0;
        dsp_halt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsp_hostwin_bridge.sv
module dsp_hostwin_bridge
  import dsp_hw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SEG_W       = 3,
  parameter int HOST_SEG    = 3,
  parameter int ARM_LIMIT_B = 3,
  localparam int OFS_W      = DATA_W - SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsp_io_we,
  input  logic              dsp_io_re,
  input  logic [1:0]        dsp_io_port,
  input  logic [DATA_W-1:0] dsp_io_wdata,
  output logic [DATA_W-1:0] dsp_io_rdata,
  output logic              dsp_io_rvalid,
  output logic              dsp_bio,
  output logic              dsp_int,
  output logic              dsp_halt,
  output logic              host_halt,
  input  logic              host_ctl_we,
  input  logic              host_ctl_lo_en,
  input  logic [7:0]        host_ctl_wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [OFS_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic             addr_ld, data_wr, data_rd, ctrl_wr, host_wr;
  logic [OFS_W-1:0] ofs;
  logic             seg_hit, ofs_low, data_arm;

  assign addr_ld  = dsp_io_we && (dsp_io_port == PORT_ADDR);
  assign data_wr  = dsp_io_we && (dsp_io_port == PORT_DATA);
  assign data_rd  = dsp_io_re && (dsp_io_port == PORT_DATA);
  assign ctrl_wr  = dsp_io_we && (dsp_io_port == PORT_CTRL);
  assign host_wr  = host_ctl_we && host_ctl_lo_en;
  assign data_arm = seg_hit && ofs_low && (dsp_io_wdata == '0);

  dsp_win_addr #(
    .DATA_W(DATA_W), .SEG_W(SEG_W), .HOST_SEG(HOST_SEG), .ARM_LIMIT_B(ARM_LIMIT_B)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(addr_ld), .wdata(dsp_io_wdata),
    .ofs(ofs), .seg_hit(seg_hit), .ofs_low(ofs_low)
  );

  dsp_win_access #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_access (
    .clk(clk), .rst_n(rst_n), .rd_req(data_rd), .wr_req(data_wr),
    .hit(seg_hit), .ofs(ofs), .wdata(dsp_io_wdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .rdata(dsp_io_rdata), .rvalid(dsp_io_rvalid)
  );

  dsp_run_ctrl #(.DATA_W(DATA_W)) u_run (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_arm(data_arm),
    .ctrl_wr(ctrl_wr), .ctrl_data(dsp_io_wdata),
    .host_wr(host_wr), .host_data(host_ctl_wdata),
    .bio(dsp_bio), .dsp_int(dsp_int), .dsp_halt(dsp_halt), .host_halt(host_halt)
  );
endmodule

// File: rtl/dsp_hostwin_chk.sv
module dsp_hostwin_chk #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dsp_io_we,
  input logic              dsp_io_re,
  input logic [1:0]        dsp_io_port,
  input logic [DATA_W-1:0] dsp_io_wdata,
  input logic [DATA_W-1:0] dsp_io_rdata,
  input logic              dsp_io_rvalid,
  input logic              dsp_bio,
  input logic              dsp_int,
  input logic              dsp_halt,
  input logic              host_halt,
  input logic              host_ctl_we,
  input logic              host_ctl_lo_en,
  input logic [7:0]        host_ctl_wdata,
  input logic              ram_en,
  input logic              ram_we,
  input logic [OFS_W-1:0]  ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [DATA_W-1:0] ram_rdata
);
  logic p3_wr;
  assign p3_wr = dsp_io_we && (dsp_io_port == 2'd3);

  a_r4_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_io_rvalid |-> $past(dsp_io_re && dsp_io_port == 2'd1));

  a_r4_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_io_rvalid |-> dsp_io_rdata == '0);

  a_r7_bio_off: assert property (@(posedge clk) disable iff (!rst_n)
    (p3_wr && dsp_io_wdata[DATA_W-1]) |=> !dsp_bio);

  a_r7_bio_on: assert property (@(posedge clk) disable iff (!rst_n)
    (p3_wr && dsp_io_wdata == '0) |=> dsp_bio);

  a_r7_bio_only_port3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dsp_bio) |-> $past(p3_wr));

  a_r7_release_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_halt) |-> $past(p3_wr && dsp_io_wdata == '0));

  a_r8_run_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctl_we && host_ctl_lo_en && host_ctl_wdata == 8'h00) |=> (host_halt && dsp_int && !dsp_halt));

  a_r9_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctl_we && host_ctl_lo_en && host_ctl_wdata == 8'h01) |=> (!dsp_int && dsp_halt));

  a_r9_int_excludes_halt: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_int |-> !dsp_halt);
endmodule

bind dsp_hostwin_bridge dsp_hostwin_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/sim_dsp_hostwin_bridge.sv
module sim_dsp_hostwin_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsp_io_we = 1'b0, dsp_io_re = 1'b0;
  logic [1:0]  dsp_io_port = 2'd0;
  logic [15:0] dsp_io_wdata = 16'h0;
  logic [15:0] dsp_io_rdata;
  logic        dsp_io_rvalid, dsp_bio, dsp_int, dsp_halt, host_halt;
  logic        host_ctl_we = 1'b0, host_ctl_lo_en = 1'b0;
  logic [7:0]  host_ctl_wdata = 8'h0;
  logic        ram_en, ram_we;
  logic [12:0] ram_addr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = 16'h0;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] ram_model [256];
  logic [15:0] exp_mem [256];
  logic [15:0] exp_q [$];
  logic [2:0]  cur_seg = 3'd0;
  logic [12:0] cur_ofs = 13'd0;

  always #10 clk = ~clk;

  dsp_hostwin_bridge u0 (.*);

  always_ff @(posedge clk) begin
    if (ram_en && ram_we) ram_model[ram_addr[7:0]] <= ram_wdata;
    if (ram_en && !ram_we) ram_rdata <= ram_model[ram_addr[7:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dsp_io_rvalid) begin
      if (exp_q.size() == 0) chk("R4 unexpected rvalid", 1, 0);
      else chk("R4/R5 read data", dsp_io_rdata, exp_q.pop_front());
    end
  end

  task automatic dsp_wr(input logic [1:0] port, input logic [15:0] d);
    @(negedge clk);
    dsp_io_we = 1'b1; dsp_io_port = port; dsp_io_wdata = d;
    if (port == 2'd0) begin cur_seg = d[15:13]; cur_ofs = d[12:0]; end
    if (port == 2'd1 && cur_seg == 3'd3) exp_mem[cur_ofs[7:0]] = d;
    @(negedge clk);
    dsp_io_we = 1'b0;
  endtask

  task automatic dsp_rd();
    @(negedge clk);
    dsp_io_re = 1'b1; dsp_io_port = 2'd1;
    exp_q.push_back(cur_seg == 3'd3 ? exp_mem[cur_ofs[7:0]] : 16'h0);
    @(negedge clk);
    dsp_io_re = 1'b0;
  endtask

  task automatic host_cmd(input logic lo, input logic [7:0] d);
    @(negedge clk);
    host_ctl_we = 1'b1; host_ctl_lo_en = lo; host_ctl_wdata = d;
    @(negedge clk);
    host_ctl_we = 1'b0; host_ctl_lo_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram_model[i] = 16'h0; exp_mem[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dsp_halt", dsp_halt, 1);
    chk("R1 dsp_int", dsp_int, 0);
    chk("R1 host_halt", host_halt, 0);
    chk("R1 dsp_bio", dsp_bio, 0);
    chk("R1 rvalid", dsp_io_rvalid, 0);
    @(negedge clk); dsp_io_re = 1'b1; dsp_io_port = 2'd1; #1;
    chk("R1 no ram_en in reset segment", ram_en, 0);
    exp_q.push_back(16'h0);
    @(negedge clk); dsp_io_re = 1'b0;

    dsp_wr(2'd0, 16'h6010);
    @(negedge clk);
    dsp_io_we = 1'b1; dsp_io_port = 2'd1; dsp_io_wdata = 16'hBEEF; exp_mem[8'h10] = 16'hBEEF; #1;
    chk("R3 ram_en", ram_en, 1);
    chk("R3 ram_we", ram_we, 1);
    chk("R2 ram_addr", ram_addr, 13'h10);
    chk("R3 ram_wdata", ram_wdata, 16'hBEEF);
    @(negedge clk); dsp_io_we = 1'b0;
    dsp_wr(2'd0, 16'h7FFE);
    @(negedge clk); dsp_io_re = 1'b1; dsp_io_port = 2'd1; #1;
    chk("R2 ram_addr top bits", ram_addr, 13'h1FFE);
    exp_q.push_back(16'h0);
    @(negedge clk); dsp_io_re = 1'b0;
    dsp_wr(2'd0, 16'h6011); dsp_wr(2'd1, 16'h1234);
    dsp_wr(2'd0, 16'h6010); dsp_rd();
    dsp_wr(2'd0, 16'h6011); dsp_rd();

    dsp_wr(2'd0, 16'h2010);
    @(negedge clk); dsp_io_we = 1'b1; dsp_io_port = 2'd1; dsp_io_wdata = 16'h5555; #1;
    chk("R5 write outside window", ram_en, 0);
    @(negedge clk); dsp_io_we = 1'b0;
    dsp_rd();
    dsp_wr(2'd0, 16'h6010); dsp_rd();

    host_cmd(1'b1, 8'h00);
    chk("R8 dsp_halt", dsp_halt, 0);
    chk("R8 dsp_int", dsp_int, 1);
    chk("R8 host_halt", host_halt, 1);
    dsp_wr(2'd0, 16'h6001); dsp_wr(2'd1, 16'h0000);
    dsp_wr(2'd3, 16'h8000);
    chk("R7 bit15 clears bio", dsp_bio, 0);
    chk("R7 bit15 keeps host halted", host_halt, 1);
    dsp_wr(2'd3, 16'h0000);
    chk("R7 zero sets bio", dsp_bio, 1);
    chk("R6 armed release", host_halt, 0);

    host_cmd(1'b1, 8'h00);
    dsp_wr(2'd3, 16'h0000);
    chk("R7 flag cleared by release", host_halt, 1);
    dsp_wr(2'd0, 16'h6000); dsp_wr(2'd1, 16'h0000); dsp_wr(2'd1, 16'h0005);
    dsp_wr(2'd3, 16'h0000);
    chk("R6 nonzero write disarms", host_halt, 1);
    dsp_wr(2'd0, 16'h6002); dsp_wr(2'd1, 16'h0000);
    dsp_wr(2'd3, 16'h0000);
    chk("R6 word 2 does not arm", host_halt, 1);
    dsp_wr(2'd0, 16'h2000); dsp_wr(2'd1, 16'h0000);
    dsp_wr(2'd3, 16'h0000);
    chk("R6 other segment does not arm", host_halt, 1);
    dsp_wr(2'd0, 16'h6000); dsp_wr(2'd1, 16'h0000);
    dsp_wr(2'd3, 16'h1234);
    chk("R7 other value bio", dsp_bio, 1);
    chk("R7 other value no release", host_halt, 1);
    dsp_wr(2'd3, 16'h0000);
    chk("R6 flag survives other value", host_halt, 0);
    dsp_wr(2'd0, 16'h6000); dsp_rd();

    host_cmd(1'b1, 8'h01);
    chk("R9 stop dsp_int", dsp_int, 0);
    chk("R9 stop dsp_halt", dsp_halt, 1);
    host_cmd(1'b1, 8'h05);
    chk("R9 unknown cmd dsp_halt", dsp_halt, 1);
    chk("R9 unknown cmd host_halt", host_halt, 0);
    host_cmd(1'b0, 8'h00);
    chk("R9 lane off dsp_int", dsp_int, 0);
    chk("R9 lane off host_halt", host_halt, 0);

    repeat (4) @(negedge clk);
    chk("R4 all reads returned", exp_q.size(), 0);
    finish_run();
  end
endmodule